// File: doc/BRIEF.md
# Dual Stack Pointer Unit

This unit keeps the two stack pointers of a small 4-bit processor core. The first pointer indexes a stack of 16-bit entries. It is a 10-bit word-address field, so its range is 000H to 3FFH. The second pointer indexes a stack of 4-bit entries. It is an 8-bit field that places the stack in memory page 00H, at addresses 0000H to 00FFH.

For each stack, the core issues push, pop or load requests on plain control pins. For every access the unit presents the memory address and afterwards moves the pointer. A push steps the pointer down first and then uses the new value. A pop uses the current value and then steps the pointer up. Both fields wrap at their own width, whatever memory is actually fitted. Each pointer is visible at all times on a readback port.

Neither pointer carries a meaningful value after reset, so software has to load both. The unit drives a permit output that masks every interrupt, non-maskable ones included, until both pointers have been loaded. If one pointer is loaded again later, the permit drops and stays low until the other pointer has also been reloaded.

The pins are plain control and status pins. Requests are sampled on every rising clock edge, and the unit never stalls a request, so there is no back-pressure.

Top module: `dual_sp_unit`

## Requirements
- R1: After reset, irq_permit is 0 and the pointers read back the parameter patterns AS_RST (default 2A5H) and DS_RST (default A5H).
- R2: A data-stack push presents ds_addr = {00H, ptr-1} in the same cycle, and the pointer reads ptr-1 from the next cycle. For example, at 50H the push uses address 004FH and the pointer becomes 4FH.
- R3: A data-stack pop presents ds_addr = {00H, ptr} in the same cycle, and the pointer reads ptr+1 from the next cycle. For example, at 4FH the pop uses address 004FH and the pointer becomes 50H.
- R4: The data-stack pointer wraps modulo 256. A push at 00H uses address 00FFH and leaves the pointer at FFH. A pop at FFH leaves the pointer at 00H.
- R5: The address-stack pointer steps by one word per entry and wraps modulo 1024. A push at 000H uses address 3FFH and leaves the pointer at 3FFH. A pop at 3FFH uses address 3FFH and leaves the pointer at 000H.
- R6: A load takes the load value into that pointer on the next edge. Any push or pop raised on the same stack in that cycle is ignored.
- R7: Push and pop raised together on one stack, with no load, raise that stack's error output (as_err or ds_err) in the same cycle and leave the pointer unchanged.
- R8: irq_permit rises one cycle after the edge on which the second of the two pointers is first loaded, in either order. A load of only one pointer keeps it at 0.
- R9: With irq_permit at 1, loading exactly one pointer drops irq_permit from the next cycle. It stays at 0 until the other pointer has been loaded as well.
- R10: Requests on one stack never change the other stack's pointer. When a stack has no push or pop, its address output shows its current pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| as_push | input | 1 | Push request, address stack |
| as_pop | input | 1 | Pop request, address stack |
| as_load | input | 1 | Software load of the address-stack pointer |
| as_load_val | input | AS_W | Value for the address-stack load |
| as_addr | output | AS_W | Word address of the current address-stack access |
| as_ptr | output | AS_W | Address-stack pointer readback |
| as_err | output | 1 | Push and pop together on the address stack |
| ds_push | input | 1 | Push request, data stack |
| ds_pop | input | 1 | Pop request, data stack |
| ds_load | input | 1 | Software load of the data-stack pointer |
| ds_load_val | input | DS_W | Value for the data-stack load |
| ds_addr | output | MEM_AW | Memory address of the current data-stack access |
| ds_ptr | output | DS_W | Data-stack pointer readback |
| ds_err | output | 1 | Push and pop together on the data stack |
| irq_permit | output | 1 | High when both pointers have been loaded as a pair |

## Verification
The first pattern is a push followed by a pop at 50H. It shows whether the address is taken before or after the step, and so separates pre-decrement from post-increment. Pushes and pops at 00H, FFH, 000H and 3FFH show whether each field wraps at its own width. They also show that the address-stack field does not wrap at the data-stack width.

Loads are tried in both orders, and then each pointer is reloaded on its own. This separates a permit that needs both pointers from one that latches once, and from one that needs only one load. Loads that clash with push or pop, and push and pop raised together, check the priority and error rules. A mixed run on both stacks then shows that neither stack disturbs the other.

// File: rtl/dual_sp_pkg.sv
package dual_sp_pkg;
  typedef enum logic [2:0] {
    OP_HOLD = 3'd0,
    OP_LOAD = 3'd1,
    OP_PUSH = 3'd2,
    OP_POP  = 3'd3,
    OP_BAD  = 3'd4
  } sp_op_e;

  // Load outranks everything; push with pop and no load is illegal.
  function automatic sp_op_e decode_op(input logic push, input logic pop, input logic load);
    if (load)              return OP_LOAD;
    else if (push && pop)  return OP_BAD;
    else if (push)         return OP_PUSH;
    else if (pop)          return OP_POP;
    else                   return OP_HOLD;
  endfunction
endpackage

// File: rtl/sp_ptr.sv
module sp_ptr
  import dual_sp_pkg::*;
#(
  parameter int          W   = 8,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] ptr,
  output logic [W-1:0] acc_addr,
  output logic         illegal
);
  localparam logic [W-1:0] ONE = W'(1);

  sp_op_e       op;
  logic [W-1:0] ptr_q;
  logic [W-1:0] ptr_dec;
  logic [W-1:0] ptr_inc;
  logic [W-1:0] ptr_d;

  assign op      = decode_op(push, pop, load);
  assign ptr_dec = ptr_q - ONE;
  assign ptr_inc = ptr_q + ONE;

  always_comb begin
    unique case (op)
      OP_LOAD: ptr_d = load_val;
      OP_PUSH: ptr_d = ptr_dec;
      OP_POP:  ptr_d = ptr_inc;
      default: ptr_d = ptr_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= RST;
    else        ptr_q <= ptr_d;
  end

  assign ptr      = ptr_q;
  assign acc_addr = (op == OP_PUSH) ? ptr_dec : ptr_q;
  assign illegal  = (op == OP_BAD);
endmodule

// File: rtl/sp_pair_lock.sv
module sp_pair_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_a,
  input  logic ld_b,
  output logic permit
);
  logic got_a;
  logic got_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      got_a <= 1'b0;
      got_b <= 1'b0;
    end else begin
      if (ld_a)                        got_a <= 1'b1;
      else if (ld_b && got_a && got_b) got_a <= 1'b0;
      if (ld_b)                        got_b <= 1'b1;
      else if (ld_a && got_a && got_b) got_b <= 1'b0;
    end
  end

  assign permit = got_a & got_b;
endmodule

// File: rtl/dual_sp_unit.sv
module dual_sp_unit #(
  parameter int              AS_W   = 10,
  parameter int              DS_W   = 8,
  parameter int              MEM_AW = 16,
  parameter logic [AS_W-1:0] AS_RST = 10'h2A5,
  parameter logic [DS_W-1:0] DS_RST = 8'hA5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              as_push,
  input  logic              as_pop,
  input  logic              as_load,
  input  logic [AS_W-1:0]   as_load_val,
  output logic [AS_W-1:0]   as_addr,
  output logic [AS_W-1:0]   as_ptr,
  output logic              as_err,
  input  logic              ds_push,
  input  logic              ds_pop,
  input  logic              ds_load,
  input  logic [DS_W-1:0]   ds_load_val,
  output logic [MEM_AW-1:0] ds_addr,
  output logic [DS_W-1:0]   ds_ptr,
  output logic              ds_err,
  output logic              irq_permit
);
  localparam int PAGE_W = MEM_AW - DS_W;

  logic [DS_W-1:0] ds_off;

  sp_ptr #(.W(AS_W), .RST(AS_RST)) u_as (
    .clk(clk), .rst_n(rst_n),
    .push(as_push), .pop(as_pop), .load(as_load), .load_val(as_load_val),
    .ptr(as_ptr), .acc_addr(as_addr), .illegal(as_err)
  );

  sp_ptr #(.W(DS_W), .RST(DS_RST)) u_ds (
    .clk(clk), .rst_n(rst_n),
    .push(ds_push), .pop(ds_pop), .load(ds_load), .load_val(ds_load_val),
    .ptr(ds_ptr), .acc_addr(ds_off), .illegal(ds_err)
  );

  // Data stack lives in page zero of the data memory.
  assign ds_addr = {{PAGE_W{1'b0}}, ds_off};

  sp_pair_lock u_lock (
    .clk(clk), .rst_n(rst_n),
    .ld_a(as_load), .ld_b(ds_load),
    .permit(irq_permit)
  );
endmodule

// File: rtl/dual_sp_unit_chk.sv
module dual_sp_unit_chk #(
  parameter int AS_W = 10,
  parameter int DS_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            as_push,
  input logic            as_pop,
  input logic            as_load,
  input logic [AS_W-1:0] as_load_val,
  input logic [AS_W-1:0] as_ptr,
  input logic            ds_push,
  input logic            ds_pop,
  input logic            ds_load,
  input logic [DS_W-1:0] ds_load_val,
  input logic [DS_W-1:0] ds_ptr,
  input logic            irq_permit
);
  localparam logic [AS_W-1:0] A1 = AS_W'(1);
  localparam logic [DS_W-1:0] D1 = DS_W'(1);

  AST_DS_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_push && !ds_pop && !ds_load) |=> ds_ptr == $past(ds_ptr) - D1); // R2
  AST_DS_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_pop && !ds_push && !ds_load) |=> ds_ptr == $past(ds_ptr) + D1); // R3
  AST_AS_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (as_push && !as_pop && !as_load) |=> as_ptr == $past(as_ptr) - A1); // R5
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ds_load |=> ds_ptr == $past(ds_load_val)); // R6
  AST_BAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (as_push && as_pop && !as_load) |=> $stable(as_ptr)); // R7
  AST_PERMIT_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_permit) |-> $past(as_load || ds_load)); // R8
  AST_PERMIT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_permit && (as_load ^ ds_load)) |=> !irq_permit); // R9
  AST_AS_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_push && !as_pop && !as_load) |=> $stable(as_ptr)); // R10
endmodule

bind dual_sp_unit dual_sp_unit_chk #(.AS_W(AS_W), .DS_W(DS_W)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .as_push(as_push), .as_pop(as_pop), .as_load(as_load), .as_load_val(as_load_val),
  .as_ptr(as_ptr),
  .ds_push(ds_push), .ds_pop(ds_pop), .ds_load(ds_load), .ds_load_val(ds_load_val),
  .ds_ptr(ds_ptr), .irq_permit(irq_permit)
);

// File: tb/dual_sp_unit_tb.sv
module dual_sp_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       as_push = 0, as_pop = 0, as_load = 0;
  logic [9:0] as_load_val = '0;
  logic [9:0] as_addr, as_ptr;
  logic       as_err;
  logic       ds_push = 0, ds_pop = 0, ds_load = 0;
  logic [7:0] ds_load_val = '0;
  logic [15:0] ds_addr;
  logic [7:0] ds_ptr;
  logic       ds_err;
  logic       irq_permit;

  always #2.5 clk = ~clk;

  dual_sp_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .as_push(as_push), .as_pop(as_pop), .as_load(as_load), .as_load_val(as_load_val),
    .as_addr(as_addr), .as_ptr(as_ptr), .as_err(as_err),
    .ds_push(ds_push), .ds_pop(ds_pop), .ds_load(ds_load), .ds_load_val(ds_load_val),
    .ds_addr(ds_addr), .ds_ptr(ds_ptr), .ds_err(ds_err),
    .irq_permit(irq_permit)
  );

  typedef struct {
    string       tag;
    logic [9:0]  as_addr;
    logic [9:0]  as_ptr;
    logic        as_err;
    logic [15:0] ds_addr;
    logic [7:0]  ds_ptr;
    logic        ds_err;
    logic        permit;
  } exp_t;

  exp_t expq[$];
  int   vectors = 0;
  int   miscompares = 0;
  bit   done = 0;

  // Bench model of the requirements
  logic [9:0] m_as = 10'h2A5;
  logic [7:0] m_ds = 8'hA5;
  bit         m_fa = 0, m_fd = 0;

  task automatic step(input string tag,
                      input bit ap, input bit aq, input bit al, input logic [9:0] av,
                      input bit dp, input bit dq, input bit dl, input logic [7:0] dv);
    exp_t e;
    @(negedge clk);
    as_push = ap; as_pop = aq; as_load = al; as_load_val = av;
    ds_push = dp; ds_pop = dq; ds_load = dl; ds_load_val = dv;
    e.tag    = tag;
    e.as_ptr = m_as;
    e.ds_ptr = m_ds;
    e.permit = m_fa && m_fd;
    e.as_err = ap && aq && !al;
    e.ds_err = dp && dq && !dl;
    e.as_addr = (ap && !aq && !al) ? m_as - 10'd1 : m_as;
    e.ds_addr = {8'h00, (dp && !dq && !dl) ? m_ds - 8'd1 : m_ds};
    expq.push_back(e);
    if (al)            m_as = av;
    else if (ap && !aq) m_as = m_as - 10'd1;
    else if (aq && !ap) m_as = m_as + 10'd1;
    if (dl)            m_ds = dv;
    else if (dp && !dq) m_ds = m_ds - 8'd1;
    else if (dq && !dp) m_ds = m_ds + 8'd1;
    if (al && !dl && m_fa && m_fd) m_fd = 0;
    if (dl && !al && m_fa && m_fd) m_fa = 0;
    if (al) m_fa = 1;
    if (dl) m_fd = 1;
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, '0, 0, 0, 0, '0);
  endtask

  // Monitor: compares each queued expectation mid-cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        vectors++;
        if (as_addr !== e.as_addr || as_ptr !== e.as_ptr || as_err !== e.as_err ||
            ds_addr !== e.ds_addr || ds_ptr !== e.ds_ptr || ds_err !== e.ds_err ||
            irq_permit !== e.permit) begin
          miscompares++;
          $display("FAIL %s: got as_addr=%h as_ptr=%h as_err=%b ds_addr=%h ds_ptr=%h ds_err=%b permit=%b, expected as_addr=%h as_ptr=%h as_err=%b ds_addr=%h ds_ptr=%h ds_err=%b permit=%b",
                   e.tag, as_addr, as_ptr, as_err, ds_addr, ds_ptr, ds_err, irq_permit,
                   e.as_addr, e.as_ptr, e.as_err, e.ds_addr, e.ds_ptr, e.ds_err, e.permit);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle("R1 reset state");
    idle("R1 reset state held");
    // R8: one load alone keeps permit low, the second load raises it
    step("R8 data pointer first", 0, 0, 0, '0, 0, 0, 1, 8'h50);
    idle("R8 one pointer only");
    step("R8 address pointer second", 0, 0, 1, 10'h3FF, 0, 0, 0, '0);
    idle("R8 pair complete");
    // R2 / R3 at 50H
    step("R2 data push at 50H", 0, 0, 0, '0, 1, 0, 0, '0);
    idle("R2 pointer after push");
    step("R3 data pop at 4FH", 0, 0, 0, '0, 0, 1, 0, '0);
    idle("R3 pointer after pop");
    // R9: reload data pointer alone
    step("R9 reload data pointer", 0, 0, 0, '0, 0, 0, 1, 8'h00);
    idle("R9 permit dropped");
    // R4 wrap on data stack
    step("R4 data push at 00H", 0, 0, 0, '0, 1, 0, 0, '0);
    step("R4 data pop at FFH", 0, 0, 0, '0, 0, 1, 0, '0);
    idle("R4 pointer back at 00H");
    idle("R9 still masked");
    step("R9 reload address pointer", 0, 0, 1, 10'h000, 0, 0, 0, '0);
    idle("R9 permit restored");
    // R5 wrap on address stack
    step("R5 address push at 000H", 1, 0, 0, '0, 0, 0, 0, '0);
    step("R5 address pop at 3FFH", 0, 1, 0, '0, 0, 0, 0, '0);
    idle("R5 pointer back at 000H");
    // R7 illegal combination
    step("R7 data push and pop", 0, 0, 0, '0, 1, 1, 0, '0);
    step("R7 address push and pop", 1, 1, 0, '0, 0, 0, 0, '0);
    idle("R7 pointers held");
    // R6 load priority
    step("R6 data load with push", 0, 0, 0, '0, 1, 0, 1, 8'h3C);
    step("R6 address load with pop and push", 1, 1, 1, 10'h155, 0, 0, 0, '0);
    idle("R6 loaded values");
    // R10 independence: mixed traffic
    for (int i = 0; i < 24; i++) begin
      step("R10 mixed traffic", i[0], i[1] & ~i[0], 0, '0, i[2] ^ i[0], i[3], 0, '0);
    end
    idle("R10 final state");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule